// File: doc/BRIEF.md
# Serial Port FIFO Request Router

This block turns the status flags of a serial port with transmit and receive FIFOs into request lines. It drives four separate level-sensitive lines towards an interrupt controller: break/overrun, receive error, receive data and transmit space. It also drives a two-bit encoded source with a valid bit, naming the most urgent request currently aimed at the CPU.

Receive-data and transmit requests can be steered to a DMA controller one channel at a time. A steered request is taken off the CPU path and appears instead on that channel's DMA request line. The DMA request drops for one cycle after each acknowledge pulse. Error and break requests always go to the CPU.

The receive-data request counts the data-ready flag only in asynchronous mode. Error and break requests can be enabled on their own, without the receive-data request. Every output is registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `sfir_router`

## Requirements
- R1: In reset (synchronous, `rst_n` low at a rising edge) every output is 0. Outside reset, the four CPU lines `brk_irq_o`, `err_irq_o`, `rx_irq_o` and `tx_irq_o` are separate registered levels.
- R2: `tx_irq_o` is 1 in the cycle after an edge at which `tx_ie_i`=1, `tx_empty_i`=1 and `tx_dma_sel_i`=0 were sampled. It returns to 0 in the cycle after any of these conditions stops holding.
- R3: `rx_irq_o` is 1 in the cycle after an edge at which `rx_ie_i`=1, `rx_dma_sel_i`=0, and either `rx_full_i`=1 or (`rx_ready_i`=1 and `async_i`=1) were sampled.
- R4: With `async_i`=0 (clocked mode), `rx_ready_i` has no effect on `rx_irq_o` or `rx_dma_req_o`. Only `rx_full_i` raises them.
- R5: `brk_irq_o` follows `brk_i` OR `ovr_i`, and `err_irq_o` follows `rx_err_i`. Both are gated by `rx_ie_i` OR `err_ie_i`, so they are produced with `rx_ie_i`=0 and `err_ie_i`=1 while `rx_irq_o` stays 0.
- R6: When `rx_dma_sel_i` (or `tx_dma_sel_i`) is 1, the receive (or transmit) request appears on `rx_dma_req_o` (or `tx_dma_req_o`) with the same one-cycle latency, and the matching CPU line stays 0. The selects never affect `brk_irq_o` or `err_irq_o`.
- R7: A DMA request stays at 1 while its condition holds. An acknowledge pulse seen at an edge while the request is 1 makes the request 0 for the next cycle. After that the request is evaluated again. If the condition clears, the request is 0 one cycle later.
- R8: `src_valid_o` is 1 exactly when at least one CPU line is 1. `src_code_o` gives the code 0=break, 1=error, 2=receive, 3=transmit, and is 0 when `src_valid_o` is 0.
- R9: The code selects by priority, highest first: break, receive error, receive data, transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_empty_i | input | 1 | Transmit FIFO has room |
| rx_full_i | input | 1 | Receive FIFO reached its fill level |
| rx_ready_i | input | 1 | Receive data waiting (asynchronous mode only) |
| rx_err_i | input | 1 | Receive error flag |
| brk_i | input | 1 | Break detected |
| ovr_i | input | 1 | Receive overrun |
| tx_ie_i | input | 1 | Transmit request enable |
| rx_ie_i | input | 1 | Receive-data request enable |
| err_ie_i | input | 1 | Error/break request enable |
| async_i | input | 1 | 1 = asynchronous mode, 0 = clocked mode |
| rx_dma_sel_i | input | 1 | Steer receive request to DMA |
| tx_dma_sel_i | input | 1 | Steer transmit request to DMA |
| rx_dma_ack_i | input | 1 | DMA acknowledge pulse, receive channel |
| tx_dma_ack_i | input | 1 | DMA acknowledge pulse, transmit channel |
| brk_irq_o | output | 1 | Break/overrun request to CPU |
| err_irq_o | output | 1 | Receive error request to CPU |
| rx_irq_o | output | 1 | Receive-data request to CPU |
| tx_irq_o | output | 1 | Transmit request to CPU |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| src_code_o | output | 2 | Code of the highest-priority CPU request |
| src_valid_o | output | 1 | A CPU request is pending |

## Verification
All state in this block is one register stage deep. A wrong internal value shows at the ports in the cycle right after the edge that loaded it. It shows up as a CPU line and a DMA line that are high together, an encoded code that disagrees with the lines, or a DMA request that survives an acknowledge. Each of these is caught on the next sample. A wrong gating term, such as data-ready counted in clocked mode or error requests tied to the receive enable alone, is seen one cycle after the stimulus that exposes it.

// File: rtl/sfir_pkg.sv
// Package: shared sizes and source codes for the serial request router.
// Assumes source index equals the encoded priority code (0 = most urgent).
package sfir_pkg;
    localparam int unsigned NUM_SRC    = 4;
    localparam int unsigned CODE_W     = $clog2(NUM_SRC);
    localparam int unsigned NUM_DMA_CH = 2;

    typedef enum logic [CODE_W-1:0] {
        SRC_BRK = 2'd0,
        SRC_ERR = 2'd1,
        SRC_RX  = 2'd2,
        SRC_TX  = 2'd3
    } src_e;

    // DMA channel indices
    localparam int unsigned CH_RX = 0;
    localparam int unsigned CH_TX = 1;
endpackage

// File: rtl/sfir_req_gen.sv
// Module: sfir_req_gen
// Combines status flags and enables into raw request conditions, one bit
// per source, indexed by source code. Purely combinational.
// Assumes flags are already synchronous to clk.
module sfir_req_gen
    import sfir_pkg::*;
(
    input  logic               tx_empty_i,
    input  logic               rx_full_i,
    input  logic               rx_ready_i,
    input  logic               rx_err_i,
    input  logic               brk_i,
    input  logic               ovr_i,
    input  logic               tx_ie_i,
    input  logic               rx_ie_i,
    input  logic               err_ie_i,
    input  logic               async_i,
    output logic [NUM_SRC-1:0] raw_o
);
    logic rx_data_avail;
    logic err_gate;

    // Purpose: derive the data-ready qualified receive condition and error gate
    always_comb begin
        rx_data_avail = rx_full_i | (rx_ready_i & async_i);
        err_gate      = rx_ie_i | err_ie_i;
    end

    // Purpose: build the per-source raw request vector
    always_comb begin
        raw_o          = '0;
        raw_o[SRC_BRK] = err_gate & (brk_i | ovr_i);
        raw_o[SRC_ERR] = err_gate & rx_err_i;
        raw_o[SRC_RX]  = rx_ie_i & rx_data_avail;
        raw_o[SRC_TX]  = tx_ie_i & tx_empty_i;
    end
endmodule

// File: rtl/sfir_prio_enc.sv
// Module: sfir_prio_enc
// Priority encoder: lowest set index wins. Gives code 0 and valid 0 when
// nothing is requested. Combinational.
module sfir_prio_enc #(
    parameter int unsigned N  = 4,
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [CW-1:0] code_o,
    output logic          valid_o
);
    // Purpose: scan from lowest priority upward so the highest priority overrides
    always_comb begin
        code_o  = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o  = CW'(i);
                valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfir_dma_chan.sv
// Module: sfir_dma_chan
// One DMA request channel. Registers the steered request; an acknowledge
// seen while requesting forces one idle cycle before re-evaluation.
// Assumes ack is a single-cycle pulse from the DMA controller.
module sfir_dma_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic sel_i,
    input  logic ack_i,
    output logic req_o
);
    logic req_q;

    // Purpose: hold request while the condition is present, drop after an ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= cond_i & sel_i & ~(ack_i & req_q);
        end
    end

    assign req_o = req_q;

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_q) |=> !req_q); // R7
    AST_DMA_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !req_q); // R6
endmodule

// File: rtl/sfir_router.sv
// Module: sfir_router (top)
// Routes serial FIFO status into four CPU request lines, two DMA request
// lines and a prioritized encoded source. All outputs are registered with
// one cycle of latency from the sampled inputs.
// Assumes all inputs are synchronous to clk.
module sfir_router
    import sfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic              rx_ready_i,
    input  logic              rx_err_i,
    input  logic              brk_i,
    input  logic              ovr_i,
    input  logic              tx_ie_i,
    input  logic              rx_ie_i,
    input  logic              err_ie_i,
    input  logic              async_i,
    input  logic              rx_dma_sel_i,
    input  logic              tx_dma_sel_i,
    input  logic              rx_dma_ack_i,
    input  logic              tx_dma_ack_i,
    output logic              brk_irq_o,
    output logic              err_irq_o,
    output logic              rx_irq_o,
    output logic              tx_irq_o,
    output logic              rx_dma_req_o,
    output logic              tx_dma_req_o,
    output logic [CODE_W-1:0] src_code_o,
    output logic              src_valid_o
);
    logic [NUM_SRC-1:0]    raw;
    logic [NUM_SRC-1:0]    cpu_next;
    logic [NUM_SRC-1:0]    cpu_q;
    logic [CODE_W-1:0]     code_next;
    logic                  valid_next;
    logic [CODE_W-1:0]     code_q;
    logic                  valid_q;
    logic [NUM_DMA_CH-1:0] ch_cond;
    logic [NUM_DMA_CH-1:0] ch_sel;
    logic [NUM_DMA_CH-1:0] ch_ack;
    logic [NUM_DMA_CH-1:0] ch_req;

    sfir_req_gen u_req_gen (
        .tx_empty_i (tx_empty_i),
        .rx_full_i  (rx_full_i),
        .rx_ready_i (rx_ready_i),
        .rx_err_i   (rx_err_i),
        .brk_i      (brk_i),
        .ovr_i      (ovr_i),
        .tx_ie_i    (tx_ie_i),
        .rx_ie_i    (rx_ie_i),
        .err_ie_i   (err_ie_i),
        .async_i    (async_i),
        .raw_o      (raw)
    );

    // Purpose: map DMA-capable sources onto channel inputs
    always_comb begin
        ch_cond        = '0;
        ch_sel         = '0;
        ch_ack         = '0;
        ch_cond[CH_RX] = raw[SRC_RX];
        ch_sel[CH_RX]  = rx_dma_sel_i;
        ch_ack[CH_RX]  = rx_dma_ack_i;
        ch_cond[CH_TX] = raw[SRC_TX];
        ch_sel[CH_TX]  = tx_dma_sel_i;
        ch_ack[CH_TX]  = tx_dma_ack_i;
    end

    // Purpose: remove DMA-steered sources from the CPU path
    always_comb begin
        cpu_next         = raw;
        cpu_next[SRC_RX] = raw[SRC_RX] & ~rx_dma_sel_i;
        cpu_next[SRC_TX] = raw[SRC_TX] & ~tx_dma_sel_i;
    end

    sfir_prio_enc #(.N(NUM_SRC)) u_prio (
        .req_i   (cpu_next),
        .code_o  (code_next),
        .valid_o (valid_next)
    );

    generate
        for (genvar c = 0; c < NUM_DMA_CH; c++) begin : g_dma
            sfir_dma_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .cond_i (ch_cond[c]),
                .sel_i  (ch_sel[c]),
                .ack_i  (ch_ack[c]),
                .req_o  (ch_req[c])
            );
        end
    endgenerate

    // Purpose: register CPU lines and encoded source together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_q   <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            cpu_q   <= cpu_next;
            code_q  <= code_next;
            valid_q <= valid_next;
        end
    end

    assign brk_irq_o    = cpu_q[SRC_BRK];
    assign err_irq_o    = cpu_q[SRC_ERR];
    assign rx_irq_o     = cpu_q[SRC_RX];
    assign tx_irq_o     = cpu_q[SRC_TX];
    assign rx_dma_req_o = ch_req[CH_RX];
    assign tx_dma_req_o = ch_req[CH_TX];
    assign src_code_o   = code_q;
    assign src_valid_o  = valid_q;

    AST_RX_NOT_BOTH_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req_o && rx_irq_o)); // R6
    AST_TX_NOT_BOTH_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req_o && tx_irq_o)); // R6
    AST_VALID_MATCHES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid_o == (brk_irq_o | err_irq_o | rx_irq_o | tx_irq_o)); // R8
    AST_BRK_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq_o |-> (src_code_o == SRC_BRK)); // R9
    AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie_i && tx_empty_i && !tx_dma_sel_i) |=> tx_irq_o); // R2
    AST_CLOCKED_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_i && !rx_full_i) |=> (!rx_irq_o && !rx_dma_req_o)); // R4
    AST_ERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie_i && !err_ie_i) |=> (!brk_irq_o && !err_irq_o)); // R5
    AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie_i && rx_full_i && !rx_dma_sel_i) |=> rx_irq_o); // R3
endmodule

// File: tb/sfir_router_tb.sv
module sfir_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_empty, rx_full, rx_ready, rx_err, brk, ovr;
    logic tx_ie, rx_ie, err_ie, async_m;
    logic rx_sel, tx_sel, rx_ack, tx_ack;
    logic brk_irq, err_irq, rx_irq, tx_irq, rx_dreq, tx_dreq;
    logic [1:0] code;
    logic valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sfir_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_empty_i(tx_empty), .rx_full_i(rx_full), .rx_ready_i(rx_ready),
        .rx_err_i(rx_err), .brk_i(brk), .ovr_i(ovr),
        .tx_ie_i(tx_ie), .rx_ie_i(rx_ie), .err_ie_i(err_ie), .async_i(async_m),
        .rx_dma_sel_i(rx_sel), .tx_dma_sel_i(tx_sel),
        .rx_dma_ack_i(rx_ack), .tx_dma_ack_i(tx_ack),
        .brk_irq_o(brk_irq), .err_irq_o(err_irq), .rx_irq_o(rx_irq),
        .tx_irq_o(tx_irq), .rx_dma_req_o(rx_dreq), .tx_dma_req_o(tx_dreq),
        .src_code_o(code), .src_valid_o(valid)
    );

    // one edge, then sample away from it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // pack lines {brk,err,rx,tx,rxdma,txdma}
    function automatic logic [31:0] lines();
        return {26'd0, brk_irq, err_irq, rx_irq, tx_irq, rx_dreq, tx_dreq};
    endfunction

    task automatic clear_inputs();
        tx_empty = 0; rx_full = 0; rx_ready = 0; rx_err = 0; brk = 0; ovr = 0;
        tx_ie = 0; rx_ie = 0; err_ie = 0; async_m = 1;
        rx_sel = 0; tx_sel = 0; rx_ack = 0; tx_ack = 0;
    endtask

    task automatic t_reset();
        clear_inputs();
        tx_ie = 1; tx_empty = 1; brk = 1; err_ie = 1;
        rst_n = 0;
        step(); step();
        check("R1 reset lines", lines(), 0);
        check("R1 reset valid", {31'd0, valid}, 0);
        check("R1 reset code", {30'd0, code}, 0);
        clear_inputs();
        rst_n = 1;
        step();
    endtask

    task automatic t_tx();
        clear_inputs();
        tx_ie = 1; tx_empty = 1;
        step();
        check("R2 tx asserted", lines(), 6'b000100);
        check("R2 tx code", {29'd0, valid, code}, {29'd0, 1'b1, 2'd3});
        tx_empty = 0;
        step();
        check("R2 tx drops after flag clear", lines(), 0);
        tx_empty = 1; tx_ie = 0;
        step();
        check("R2 tx off with enable 0", lines(), 0);
    endtask

    task automatic t_rx();
        clear_inputs();
        rx_ie = 1; rx_ready = 1; async_m = 1;
        step();
        check("R3 rx from ready in async", lines(), 6'b001000);
        async_m = 0;
        step();
        check("R4 ready ignored in clocked mode", lines(), 0);
        rx_sel = 1;
        step();
        check("R4 ready ignored for dma in clocked mode", lines(), 0);
        rx_sel = 0; rx_full = 1;
        step();
        check("R3 rx from full in clocked mode", lines(), 6'b001000);
        check("R8 rx code", {29'd0, valid, code}, {29'd0, 1'b1, 2'd2});
        rx_ie = 0;
        step();
        check("R3 rx off with enable 0", lines(), 0);
    endtask

    task automatic t_err_brk();
        clear_inputs();
        rx_ie = 0; err_ie = 1; rx_full = 1; brk = 1;
        step();
        check("R5 break without rx data", lines(), 6'b100000);
        brk = 0; ovr = 1;
        step();
        check("R5 overrun drives break line", lines(), 6'b100000);
        ovr = 0; rx_err = 1;
        step();
        check("R5 error line", lines(), 6'b010000);
        check("R8 error code", {29'd0, valid, code}, {29'd0, 1'b1, 2'd1});
        err_ie = 0; rx_ie = 1; rx_full = 0;
        step();
        check("R5 error gated by rx enable", lines(), 6'b010000);
        rx_ie = 0; brk = 1;
        step();
        check("R5 both enables off", lines(), 0);
        check("R8 none valid", {29'd0, valid, code}, 0);
    endtask

    task automatic t_dma();
        clear_inputs();
        rx_ie = 1; rx_full = 1; rx_sel = 1; err_ie = 1; rx_err = 1;
        step();
        check("R6 rx steered to dma, error stays cpu", lines(), 6'b010010);
        step();
        check("R7 rx dma held", lines(), 6'b010010);
        rx_ack = 1;
        step();
        check("R7 rx dma low after ack", {31'd0, rx_dreq}, 0);
        rx_ack = 0;
        step();
        check("R7 rx dma reasserts", {31'd0, rx_dreq}, 1);
        rx_full = 0;
        step();
        check("R7 rx dma drops on flag clear", {31'd0, rx_dreq}, 0);
        clear_inputs();
        tx_ie = 1; tx_empty = 1; tx_sel = 1;
        step();
        check("R6 tx steered to dma", lines(), 6'b000001);
        check("R6 tx dma leaves no cpu code", {31'd0, valid}, 0);
        tx_ack = 1;
        step();
        check("R7 tx dma low after ack", {31'd0, tx_dreq}, 0);
        tx_ack = 0; tx_sel = 0;
        step();
        check("R6 tx back to cpu", lines(), 6'b000100);
    endtask

    task automatic t_prio();
        clear_inputs();
        tx_ie = 1; tx_empty = 1; rx_ie = 1; rx_full = 1; rx_err = 1; brk = 1;
        step();
        check("R9 all pending -> break", {29'd0, valid, code}, {29'd0, 1'b1, 2'd0});
        brk = 0;
        step();
        check("R9 error over rx/tx", {29'd0, valid, code}, {29'd0, 1'b1, 2'd1});
        rx_err = 0;
        step();
        check("R9 rx over tx", {29'd0, valid, code}, {29'd0, 1'b1, 2'd2});
        rx_full = 0;
        step();
        check("R9 tx alone", {29'd0, valid, code}, {29'd0, 1'b1, 2'd3});
        tx_empty = 0;
        step();
        check("R8 idle code", {29'd0, valid, code}, 0);
    endtask

    initial begin
        clear_inputs();
        rst_n = 0;
        t_reset();
        t_tx();
        t_rx();
        t_err_brk();
        t_dma();
        t_prio();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule